// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous memory with registered controls, a 32-bit word made of four byte lanes, and registered read data. An access starts when an address strobe is sampled low while the three chip enables are active. Two strobes are available. The processor-side strobe wins over the controller-side strobe and always opens a read. The controller-side strobe can open a read or perform a one-cycle write. While a burst is open and both strobes are high, a step input chooses between two actions. It can move to the next burst address, whose two low bits the surrounding logic supplies from the current low bits. Or it can hold the current address.

Read data leaves through an output register, one clock after the address edge. An asynchronous active-low output enable gates it onto the bus. The bus is modelled as a data-in port, a data-out port and a drive-enable port. The drive enable is forced low in four cases: on write cycles, on deselects, in the first cycle after leaving deselect, and after a write until a strobe or step cycle arrives. The word depth is a parameter (2^AW words). Setting AW to 15 gives the full 32K-word array.

Top module: `pipe_burst_sram`

## Requirements
- R1: An access (read or write) is registered only when a strobe is taken and all enables are active: `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0. A taken strobe with any enable inactive deselects the block and writes nothing.
- R2: When both strobes are low, only `cpu_strobe_n` is recognised. While `sel_a_n` is high, `cpu_strobe_n` has no effect at all, and an open burst simply continues.
- R3: A `cpu_strobe_n` access is always a read, whatever the write inputs show. In a later cycle of the same burst, a write to the held address does take effect.
- R4: A `ctl_strobe_n` write stores its data at the presented address in the same edge, and `step_n` is ignored in that cycle.
- R5: Lane i is `din[8i+7:8i]` and is selected by `lane_sel_n[i]`=0. With `all_wr_n`=0 all four lanes are written. Otherwise a lane is written only when `lane_wr_n`=0 and its select is 0. Unwritten lanes keep their contents.
- R6: Read data for an address registered at edge k appears on `dout` after edge k+1. `dout_en` follows `out_en_n` without waiting for a clock.
- R7: After an edge that performs a write, `dout_en` is 0 regardless of `out_en_n`.
- R8: After the edge that opens an access from the deselected state, `dout_en` stays 0 for that cycle.
- R9: After an edge that registers a deselect, `dout_en` is 0 at once.
- R10: With both strobes high in an open burst, `step_n`=0 replaces the address low two bits with `burst_nxt_lo`, and `step_n`=1 keeps the address. This holds for reads and writes. `burst_lo` shows the current low bits.
- R11: During and right after reset, no access is open and `dout_en` is 0.
- R12: After a write, hold cycles (strobes high, `step_n`=1) keep `dout_en` at 0. The next strobe or step read restores driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address taken on a strobe |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_n | input | 1 | Byte-lane write qualifier, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | 32 | Write data |
| burst_nxt_lo | input | 2 | Next burst low address bits from external order logic |
| burst_lo | output | 2 | Current burst low address bits |
| dout | output | 32 | Read data (zero when not driven) |
| dout_en | output | 1 | Bus drive enable |

## Verification
Most wrong internal state shows up as a wrong `dout_en` one edge later. A pending-read flag that survives a write or a deselect drives the bus when it must float. A lost open-burst flag makes hold cycles end the read early. A wrong address register or byte-lane enable does not show when the write happens. It shows only when that word is read back, two edges after the read strobe. So the bench pairs every write pattern with a read-back, and it walks a burst through the wrap from low bits 3 to 0.

// File: rtl/pipe_burst_sram_pkg.sv
package pipe_burst_sram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_DESEL = 2'd1,
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_kind_e;

endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
    import pipe_burst_sram_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LANES = 4
) (
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             step_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic [AW-1:0]    ext_addr,
    input  logic [AW-1:0]    cur_addr,
    input  logic [1:0]       nxt_lo,
    input  logic             open_q,
    output cyc_kind_e        kind,
    output logic [AW-1:0]    acc_addr,
    output logic [LANES-1:0] lane_we,
    output logic             strobe_taken
);
    logic             cpu_go;
    logic             ctl_go;
    logic             chip_on;
    logic [LANES-1:0] lane_req;

    always_comb begin
        cpu_go       = !cpu_strobe_n && !sel_a_n;
        ctl_go       = !ctl_strobe_n && !cpu_go;
        chip_on      = !sel_a_n && sel_b && !sel_c_n;
        strobe_taken = cpu_go || ctl_go;
        if (!all_wr_n)       lane_req = '1;
        else if (!lane_wr_n) lane_req = ~lane_sel_n;
        else                 lane_req = '0;

        kind     = CYC_IDLE;
        acc_addr = cur_addr;
        lane_we  = '0;
        if (strobe_taken) begin
            if (chip_on) begin
                acc_addr = ext_addr;
                if (ctl_go && (|lane_req)) begin
                    kind    = CYC_WRITE;
                    lane_we = lane_req;
                end else begin
                    kind = CYC_READ;
                end
            end else begin
                kind = CYC_DESEL;
            end
        end else if (open_q) begin
            if (!step_n) acc_addr = {cur_addr[AW-1:2], nxt_lo};
            if (|lane_req) begin
                kind    = CYC_WRITE;
                lane_we = lane_req;
            end else begin
                kind = CYC_READ;
            end
        end
    end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int AW    = 10,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic [LANES-1:0]    we,
    input  logic [AW-1:0]       waddr,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) cells[waddr] <= wdata[g*LW +: LW];
        end

        assign rdata[g*LW +: LW] = cells[raddr];
    end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import pipe_burst_sram_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rdata,
    input  logic          pend_q,
    input  cyc_kind_e     kind,
    input  logic          out_en_n,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    typedef struct packed {
        logic          drive;
        logic [DW-1:0] data;
    } ostate_t;

    ostate_t st_d, st_q;

    always_comb begin
        st_d.data  = rdata;
        st_d.drive = pend_q && (kind != CYC_WRITE) && (kind != CYC_DESEL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_en = st_q.drive && !out_en_n;
    assign dout    = dout_en ? st_q.data : '0;
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import pipe_burst_sram_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                cpu_strobe_n,
    input  logic                ctl_strobe_n,
    input  logic                step_n,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                all_wr_n,
    input  logic                lane_wr_n,
    input  logic [LANES-1:0]    lane_sel_n,
    input  logic                out_en_n,
    input  logic [LANES*LW-1:0] din,
    input  logic [1:0]          burst_nxt_lo,
    output logic [1:0]          burst_lo,
    output logic [LANES*LW-1:0] dout,
    output logic                dout_en
);
    localparam int DW = LANES * LW;

    typedef struct packed {
        logic          open;
        logic          pend;
        logic [AW-1:0] addr;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    cyc_kind_e        kind;
    logic [AW-1:0]    acc_addr;
    logic [LANES-1:0] lane_we;
    logic             strobe_taken;
    logic [DW-1:0]    rdata;

    sram_cycle_decode #(.AW(AW), .LANES(LANES)) u_dec (
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .step_n       (step_n),
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .all_wr_n     (all_wr_n),
        .lane_wr_n    (lane_wr_n),
        .lane_sel_n   (lane_sel_n),
        .ext_addr     (addr),
        .cur_addr     (ctl_q.addr),
        .nxt_lo       (burst_nxt_lo),
        .open_q       (ctl_q.open),
        .kind         (kind),
        .acc_addr     (acc_addr),
        .lane_we      (lane_we),
        .strobe_taken (strobe_taken)
    );

    sram_lane_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
        .clk   (clk),
        .we    (lane_we),
        .waddr (acc_addr),
        .wdata (din),
        .raddr (ctl_q.addr),
        .rdata (rdata)
    );

    sram_out_stage #(.DW(DW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdata    (rdata),
        .pend_q   (ctl_q.pend),
        .kind     (kind),
        .out_en_n (out_en_n),
        .dout     (dout),
        .dout_en  (dout_en)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (kind)
            CYC_DESEL: begin
                ctl_d.open = 1'b0;
                ctl_d.pend = 1'b0;
            end
            CYC_READ: begin
                ctl_d.open = 1'b1;
                ctl_d.addr = acc_addr;
                ctl_d.pend = strobe_taken || !step_n || ctl_q.pend;
            end
            CYC_WRITE: begin
                ctl_d.open = 1'b1;
                ctl_d.addr = acc_addr;
                ctl_d.pend = 1'b0;
            end
            default: ctl_d.pend = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign burst_lo = ctl_q.addr[1:0];

    // R3: a taken processor strobe never writes
    assert_cpu_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && !sel_a_n) |-> (lane_we == '0));

    // R5: whole-word write reaches every lane
    assert_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_wr_n && (lane_we != '0)) |-> (&lane_we));

    // R1 and R9: a strobe with an inactive enable floats the bus next cycle
    assert_desel_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (((!cpu_strobe_n && !sel_a_n) || !ctl_strobe_n) && (sel_a_n || !sel_b || sel_c_n))
        |=> !dout_en);

    // R7: a write edge floats the bus
    assert_write_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |=> !dout_en);

    // R8: first cycle out of deselect stays floating
    assert_first_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_READ && !ctl_q.open) |=> !dout_en);

    // R12: hold cycles after a write keep the bus floating
    assert_hold_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_READ && !strobe_taken && step_n && !ctl_q.pend) |=> !dout_en);

    // R6: a pending read followed by a read edge drives exactly when enabled
    assert_read_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pend && kind == CYC_READ) |=> (dout_en == !out_en_n));
endmodule

// File: tb/pipe_burst_sram_tb.sv
`timescale 1ns/1ps
module pipe_burst_sram_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  addr;
    logic        cpu_strobe_n, ctl_strobe_n, step_n;
    logic        sel_a_n, sel_b, sel_c_n;
    logic        all_wr_n, lane_wr_n;
    logic [3:0]  lane_sel_n;
    logic        out_en_n;
    logic [31:0] din;
    logic [1:0]  burst_nxt_lo, burst_lo;
    logic [31:0] dout;
    logic        dout_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // linear burst order supplied by the bench
    assign burst_nxt_lo = burst_lo + 2'd1;

    pipe_burst_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .step_n(step_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .din(din), .burst_nxt_lo(burst_nxt_lo),
        .burst_lo(burst_lo), .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic [9:0]  a;
        logic [31:0] d;
        logic        gw;
        logic        bwe;
        logic [3:0]  bw;
        logic        wr;
        logic [31:0] e;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'h010, 32'hA5A5_0F0F, 1'b0, 1'b1, 4'hF,    1'b1, 32'hA5A5_0F0F},
        '{10'h010, 32'h1122_3344, 1'b1, 1'b0, 4'b1010, 1'b1, 32'hA522_0F44},
        '{10'h3FF, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'b0000, 1'b1, 32'hDEAD_BEEF},
        '{10'h3FF, 32'h0BAD_F00D, 1'b0, 1'b1, 4'hF,    1'b1, 32'h0BAD_F00D},
        '{10'h3FF, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b0000, 1'b0, 32'h0BAD_F00D},
        '{10'h000, 32'h1357_9BDF, 1'b0, 1'b1, 4'hF,    1'b1, 32'h1357_9BDF},
        '{10'h000, 32'hAA00_0000, 1'b1, 1'b0, 4'b0111, 1'b1, 32'hAA57_9BDF},
        '{10'h155, 32'hCAFE_0001, 1'b0, 1'b1, 4'hF,    1'b1, 32'hCAFE_0001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_idle();
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; step_n = 1'b1;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF;
        out_en_n = 1'b0;
    endtask

    task automatic cpu_read(input logic [9:0] a);
        set_idle(); addr = a; cpu_strobe_n = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; din = '0;
        set_idle();
        step(); step();
        chk("R11 reset", {31'd0, dout_en}, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R11 after reset", {31'd0, dout_en}, 32'd0);

        // table: controller write then processor read-back
        for (int i = 0; i < 8; i++) begin
            set_idle();
            addr = VECS[i].a; din = VECS[i].d; ctl_strobe_n = 1'b0;
            all_wr_n = VECS[i].gw; lane_wr_n = VECS[i].bwe; lane_sel_n = VECS[i].bw;
            step();
            if (VECS[i].wr) chk("R7 write floats", {31'd0, dout_en}, 32'd0);
            cpu_read(VECS[i].a);
            step();
            set_idle();
            step();
            chk("R5 R4 readback", dout, VECS[i].e);
            chk("R6 drive", {31'd0, dout_en}, 32'd1);
        end

        // R9: deselect through sel_b
        set_idle(); ctl_strobe_n = 1'b0; sel_b = 1'b0; addr = 10'h3FF;
        all_wr_n = 1'b0; din = 32'h0;
        step();
        chk("R9 deselect floats", {31'd0, dout_en}, 32'd0);
        // R8: first access out of deselect
        cpu_read(10'h3FF);
        step();
        chk("R8 first cycle floats", {31'd0, dout_en}, 32'd0);
        set_idle();
        step();
        chk("R8 then drives", {31'd0, dout_en}, 32'd1);
        chk("R1 no write while deselected", dout, 32'h0BAD_F00D);
        // R6: asynchronous output enable
        out_en_n = 1'b1; #1;
        chk("R6 oe high floats", {31'd0, dout_en}, 32'd0);
        out_en_n = 1'b0; #1;
        chk("R6 oe low drives", {31'd0, dout_en}, 32'd1);

        // R2: processor strobe ignored while sel_a_n high
        set_idle(); cpu_strobe_n = 1'b0; sel_a_n = 1'b1; addr = 10'h000;
        step();
        chk("R2 ignored strobe keeps drive", {31'd0, dout_en}, 32'd1);
        set_idle();
        step();
        chk("R2 burst unchanged", dout, 32'h0BAD_F00D);

        // R2/R3: both strobes low with write inputs -> read only
        set_idle(); cpu_strobe_n = 1'b0; ctl_strobe_n = 1'b0; addr = 10'h155;
        all_wr_n = 1'b0; din = 32'h0;
        step();
        set_idle();
        step();
        chk("R3 R2 strobe read did not write", dout, 32'hCAFE_0001);
        // R3: later cycle write to held address
        set_idle(); all_wr_n = 1'b0; din = 32'h7777_8888;
        step();
        chk("R7 continue write floats", {31'd0, dout_en}, 32'd0);
        set_idle();
        step();
        chk("R12 hold after write", {31'd0, dout_en}, 32'd0);
        step();
        chk("R12 second hold", {31'd0, dout_en}, 32'd0);
        cpu_read(10'h155);
        step();
        set_idle();
        step();
        chk("R3 later write landed", dout, 32'h7777_8888);
        chk("R12 strobe restores drive", {31'd0, dout_en}, 32'd1);

        // R1: write with sel_c_n inactive is dropped
        set_idle(); ctl_strobe_n = 1'b0; sel_c_n = 1'b1; addr = 10'h155;
        all_wr_n = 1'b0; din = 32'h0;
        step();
        chk("R1 deselect floats", {31'd0, dout_en}, 32'd0);
        cpu_read(10'h155);
        step();
        set_idle();
        step();
        chk("R1 data kept", dout, 32'h7777_8888);

        // R4/R10: burst write with step and hold, wrapping at low bits
        set_idle(); ctl_strobe_n = 1'b0; step_n = 1'b0; addr = 10'h200;
        all_wr_n = 1'b0; din = 32'h1000_0000;
        step();
        chk("R10 burst_lo after load", {30'd0, burst_lo}, 32'd0);
        set_idle(); all_wr_n = 1'b0; step_n = 1'b0; din = 32'h1000_0001; step();
        set_idle(); all_wr_n = 1'b0; step_n = 1'b1; din = 32'h1000_00AA; step();
        chk("R10 hold keeps address", {30'd0, burst_lo}, 32'd1);
        set_idle(); all_wr_n = 1'b0; step_n = 1'b0; din = 32'h1000_0002; step();
        set_idle(); all_wr_n = 1'b0; step_n = 1'b0; din = 32'h1000_0003; step();
        set_idle(); all_wr_n = 1'b0; step_n = 1'b0; din = 32'h1000_0004; step();
        chk("R10 wrap to low bits 0", {30'd0, burst_lo}, 32'd0);
        // burst read from low bits 2
        cpu_read(10'h202);
        step();
        set_idle(); step_n = 1'b0;
        step();
        chk("R10 read lo2", dout, 32'h1000_0002);
        step();
        chk("R10 read lo3", dout, 32'h1000_0003);
        step();
        chk("R10 R4 read lo0 wrapped", dout, 32'h1000_0004);
        step_n = 1'b1;
        step();
        chk("R10 read lo1 held write", dout, 32'h1000_00AA);
        step();
        chk("R10 suspend holds", dout, 32'h1000_00AA);
        chk("R10 suspend still drives", {31'd0, dout_en}, 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule